// File: doc/BRIEF.md
# Binary-Countdown Bus Arbiter with Fairness Lockout

This block chooses one bus master from a set of N requesting modules (N a power of two, 8 by default). It does not use a central priority encoder. Every module has its own cell, and all cells share W = log2(N) arbitration lines. Each line behaves like a wired-AND, which is built in the chip as an AND of what every cell drives. A cell that takes part in a round puts its own binary number on the lines. A cell that does not take part drives all ones.

The lines are resolved one bit per clock, starting at the most significant bit. If the line value in the current bit position differs from a cell's own bit, that cell withdraws at the end of that cycle and drives all ones from then on. After W cycles only the lowest-numbered participant is left. It receives a one-hot grant together with its number.

A fixed order like this would starve the high-numbered modules, so the block adds a lockout:
- A module that has won sits out of later rounds.
- The lockout lasts until none of the modules that are still allowed to compete is requesting.
- At that point every lock is cleared.

Top module: `cdarb_top`

## Requirements
- R1: While reset is asserted, and after it is released, `gnt_o` is zero and `gnt_valid_o` is low. Reset also clears every lockout flag.
- R2: Each round grants the lowest-numbered module among those that were eligible, meaning requesting and not locked out, when the round started. With requesters 1, 3 and 6 and no locks, module 1 wins.
- R3: A round starts on a clock edge at which the arbiter is idle and at least one eligible request is present. `gnt_valid_o` is high during exactly the one cycle that follows W further edges, and is low in the cycles before and after it.
- R4: When `gnt_valid_o` is high, `gnt_o` has exactly one bit set (bit i means module i won) and `gnt_id_o` holds i as an unsigned binary number. When `gnt_valid_o` is low, `gnt_o` is zero.
- R5: If no module is requesting, no grant is issued.
- R6: Participation is fixed at the start of a round. A request raised during a round does not take part in it, and a participant that drops its request during the round stays in it.
- R7: A module that wins is locked out. It does not take part in later rounds while any unlocked module is requesting.
- R8: On an idle cycle in which no unlocked module is requesting and some lock is set, all locks clear. A round among the remaining requesters then starts on the following edge, which adds one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | N_MODS | Request from each module |
| gnt_o | output | N_MODS | One-hot grant, valid with `gnt_valid_o` |
| gnt_valid_o | output | 1 | One-cycle pulse marking the result of a round |
| gnt_id_o | output | log2(N_MODS) | Number of the winning module |

## Verification
A walked vector table replays the three-way contention among modules 1, 3 and 6 until every one of them has been served. A design that lets a winner take part again would keep granting module 1, and one that forgets to clear the locks would stop granting at all. Several rows need a lock release before their round can start. A design that ignores the extra release cycle, or that starts a round on a locked-only request set, would raise the grant one cycle early or pick a locked winner.

A directed test swaps the requesters in the middle of a round. A design that samples requests continuously would grant the newcomer, and one that drops a participant when its request falls would grant nobody. A reset asserted in the middle of a round must cancel the grant and clear the locks.

// File: rtl/cdarb_pkg.sv
package cdarb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RESOLVE = 2'd1,
    ST_DONE    = 2'd2
  } cd_state_e;

endpackage

// File: rtl/cdarb_rst_sync.sv
module cdarb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cdarb_lines.sv
module cdarb_lines #(
  parameter int N_MODS = 8,
  localparam int W = $clog2(N_MODS)
) (
  input  logic [N_MODS*W-1:0] drive_flat_i,
  output logic [W-1:0]        line_o
);

  logic [W-1:0][N_MODS-1:0] column;

  // Each line is the AND of every cell's drive for that bit: any 0 wins.
  for (genvar b = 0; b < W; b++) begin : g_line
    for (genvar m = 0; m < N_MODS; m++) begin : g_tap
      assign column[b][m] = drive_flat_i[m*W + b];
    end
    assign line_o[b] = &column[b];
  end

endmodule

// File: rtl/cdarb_cell.sv
module cdarb_cell #(
  parameter int N_MODS = 8,
  parameter int ID     = 0,
  localparam int W = $clog2(N_MODS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic         start_i,
  input  logic         resolve_i,
  input  logic         done_i,
  input  logic         release_i,
  input  logic [W-1:0] bit_mask_i,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] drive_o,
  output logic         elig_o,
  output logic         lock_o,
  output logic         gnt_o
);

  localparam logic [W-1:0] ID_BITS = W'(ID);

  logic active_q, active_d, active_en;
  logic lock_q, lock_d, lock_en;
  logic mismatch;

  // Compare only the bit position being resolved in this cycle.
  assign mismatch = |((line_i ^ ID_BITS) & bit_mask_i);
  assign elig_o   = req_i & ~lock_q;
  assign drive_o  = active_q ? ID_BITS : {W{1'b1}};
  assign gnt_o    = done_i & active_q;
  assign lock_o   = lock_q;

  always_comb begin
    active_en = 1'b0;
    active_d  = active_q;
    if (start_i) begin
      active_en = 1'b1;
      active_d  = elig_o;
    end else if (resolve_i && mismatch) begin
      active_en = 1'b1;
      active_d  = 1'b0;
    end else if (done_i) begin
      active_en = 1'b1;
      active_d  = 1'b0;
    end
  end

  always_comb begin
    lock_en = 1'b0;
    lock_d  = lock_q;
    if (release_i) begin
      lock_en = 1'b1;
      lock_d  = 1'b0;
    end else if (gnt_o) begin
      lock_en = 1'b1;
      lock_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      if (active_en) active_q <= active_d;
      if (lock_en)   lock_q   <= lock_d;
    end
  end

  AST_LOCKED_STAYS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && lock_q) |=> !active_q); // R7
  AST_WIN_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o |=> lock_q); // R7
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_i && !active_q) |=> !active_q); // R6

endmodule

// File: rtl/cdarb_seq.sv
module cdarb_seq
  import cdarb_pkg::*;
#(
  parameter int N_MODS = 8,
  localparam int W = $clog2(N_MODS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         any_elig_i,
  input  logic         any_lock_i,
  output logic         start_o,
  output logic         resolve_o,
  output logic         done_o,
  output logic         release_o,
  output logic [W-1:0] bit_mask_o
);

  localparam logic [W-1:0] MSB_MASK = W'(1) << (W - 1);

  cd_state_e    state_q, state_d;
  logic [W-1:0] mask_q, mask_d;
  logic         mask_en;

  assign start_o    = (state_q == ST_IDLE) & any_elig_i;
  assign release_o  = (state_q == ST_IDLE) & ~any_elig_i & any_lock_i;
  assign resolve_o  = (state_q == ST_RESOLVE);
  assign done_o     = (state_q == ST_DONE);
  assign bit_mask_o = mask_q;

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    mask_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_elig_i) begin
          state_d = ST_RESOLVE;
          mask_d  = MSB_MASK;
          mask_en = 1'b1;
        end
      end
      ST_RESOLVE: begin
        mask_en = 1'b1;
        mask_d  = mask_q >> 1;
        if (mask_q[0]) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        mask_d  = '0;
        mask_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  AST_ROUND_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESOLVE && mask_q[0]) |=> (state_q == ST_DONE)); // R3
  AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESOLVE) |-> ($countones(mask_q) == 1)); // R3
  AST_DONE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE)); // R3

endmodule

// File: rtl/cdarb_top.sv
module cdarb_top #(
  parameter int N_MODS = 8,
  localparam int W = $clog2(N_MODS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MODS-1:0] req_i,
  output logic [N_MODS-1:0] gnt_o,
  output logic              gnt_valid_o,
  output logic [W-1:0]      gnt_id_o
);

  logic                rst_q_n;
  logic                start, resolve, done, release_all;
  logic [W-1:0]        bit_mask;
  logic [W-1:0]        line;
  logic [N_MODS*W-1:0] drive_flat;
  logic [N_MODS-1:0]   elig, lock, gnt;

  cdarb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  cdarb_seq #(.N_MODS(N_MODS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .any_elig_i (|elig),
    .any_lock_i (|lock),
    .start_o    (start),
    .resolve_o  (resolve),
    .done_o     (done),
    .release_o  (release_all),
    .bit_mask_o (bit_mask)
  );

  for (genvar m = 0; m < N_MODS; m++) begin : g_cell
    cdarb_cell #(.N_MODS(N_MODS), .ID(m)) u_cell (
      .clk        (clk),
      .rst_n      (rst_q_n),
      .req_i      (req_i[m]),
      .start_i    (start),
      .resolve_i  (resolve),
      .done_i     (done),
      .release_i  (release_all),
      .bit_mask_i (bit_mask),
      .line_i     (line),
      .drive_o    (drive_flat[m*W +: W]),
      .elig_o     (elig[m]),
      .lock_o     (lock[m]),
      .gnt_o      (gnt[m])
    );
  end

  cdarb_lines #(.N_MODS(N_MODS)) u_lines (
    .drive_flat_i (drive_flat),
    .line_o       (line)
  );

  // After the last bit only the winner drives, so the lines carry its number.
  assign gnt_o       = gnt;
  assign gnt_valid_o = done;
  assign gnt_id_o    = done ? line : '0;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q_n)
    gnt_valid_o |-> ($countones(gnt_o) == 1)); // R4
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !gnt_valid_o |-> (gnt_o == '0)); // R4
  AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
    gnt_valid_o |-> gnt_o[gnt_id_o]); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    gnt_valid_o |=> !gnt_valid_o); // R3

endmodule

// File: tb/cdarb_top_tb.sv
module cdarb_top_tb;

  localparam int N = 8;
  localparam int W = 3;
  localparam int NV = 12;

  // Vector: {request, grant expected, winner id, extra release cycle}
  localparam logic [12:0] VEC [NV] = '{
    {8'h4A, 1'b1, 3'd1, 1'b0},
    {8'h4A, 1'b1, 3'd3, 1'b0},
    {8'h4A, 1'b1, 3'd6, 1'b0},
    {8'h4A, 1'b1, 3'd1, 1'b1},
    {8'h00, 1'b0, 3'd0, 1'b0},
    {8'h80, 1'b1, 3'd7, 1'b0},
    {8'hFF, 1'b1, 3'd0, 1'b0},
    {8'hFF, 1'b1, 3'd1, 1'b0},
    {8'h81, 1'b1, 3'd0, 1'b1},
    {8'h06, 1'b1, 3'd1, 1'b0},
    {8'h03, 1'b1, 3'd0, 1'b1},
    {8'h20, 1'b1, 3'd5, 1'b0}
  };

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] gnt;
  logic         gnt_valid;
  logic [W-1:0] gnt_id;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  cdarb_top #(.N_MODS(N)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .gnt_o       (gnt),
    .gnt_valid_o (gnt_valid),
    .gnt_id_o    (gnt_id)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at a negedge while idle; check every cycle of the round.
  task automatic run_round(input logic [N-1:0] r, input bit ev, input int eid,
                           input bit rel, input string tag);
    int lat;
    lat = W + 1 + (rel ? 1 : 0);
    req = r;
    for (int i = 1; i <= lat + 1; i++) begin
      @(negedge clk);
      if (i < lat) begin
        chk(gnt_valid == 1'b0, {tag, " R3 early"}, gnt_valid, 0);
      end else if (i == lat) begin
        chk(gnt_valid == ev, {tag, " R3 valid"}, gnt_valid, ev);
        if (ev) begin
          chk(gnt == (N'(1) << eid), {tag, " R2 grant"}, gnt, N'(1) << eid);
          chk(gnt_id == W'(eid), {tag, " R4 id"}, gnt_id, eid);
        end else begin
          chk(gnt == '0, {tag, " R5 no grant"}, gnt, 0);
        end
      end else begin
        chk(gnt_valid == 1'b0 && gnt == '0, {tag, " R3 pulse"}, gnt_valid, 0);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req   = '0;
    repeat (3) @(negedge clk);
    chk(gnt == '0 && gnt_valid == 1'b0, "R1 in reset", gnt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(gnt == '0 && gnt_valid == 1'b0, "R1 after reset", gnt, 0);

    for (int v = 0; v < NV; v++) begin
      run_round(VEC[v][12:5], VEC[v][4], int'(VEC[v][3:1]), VEC[v][0], "vector R7 R8");
    end

    // R6: locks are {0,5}; module 4 starts, then 4 drops and 2 raises mid-round.
    req = 8'h10;
    @(negedge clk);
    req = 8'h04;
    for (int i = 2; i <= W + 2; i++) begin
      @(negedge clk);
      if (i == W + 1) begin
        chk(gnt_valid && gnt == 8'h10, "R6 sampled at start", gnt, 8'h10);
      end
    end
    run_round(8'h04, 1'b1, 2, 1'b0, "R6 late raiser next round");

    // R1: reset in mid-round cancels the grant and clears locks.
    req = 8'h40;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    req   = '0;
    for (int i = 0; i < W + 2; i++) begin
      @(negedge clk);
      chk(gnt_valid == 1'b0, "R1 mid-round reset", gnt_valid, 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_round(8'h01, 1'b1, 0, 1'b0, "R1 locks cleared");
    run_round(8'h00, 1'b0, 0, 1'b1, "R5 idle");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule